// File: doc/BRIEF.md
# Multi-Mode Barrel Shifter

A purely combinational shifter that puts six shift flavours behind one set of pins. It takes a data operand `a` of width `AW` and a shift amount `b` of width `BW`. Two flags state whether each operand is to be read as two's complement, and a 3-bit operation code picks the flavour. The result `y` has its own width `YW`. Each output bit is computed as an index lookup. Output bit i reads operand bit (i + offset), where the offset is +amount for a rightward move and −amount for a leftward one. Positions that land outside the operand take a fill value that depends on the mode and on which side they fall.

Depending on the mode, the operand is either first widened to EW = max(YW, AW), by sign extension when `a_signed` is set and by zero extension otherwise, or used as is. In the two bidirectional modes a two's-complement amount may be negative, and a negative amount moves the data left by its magnitude. The undefined-fill mode has no X in its logic. Its vacant positions take the value on `fill_bit`, so a simulation model can drive X there and a netlist sees an ordinary input. The block has no state. There is no handshake at its edge: every pin is plain control or data, and `y` follows the inputs within the same cycle.

Top module: `bshift`

## Requirements
- R1: Mode 0 (logical left): `y` is the low YW bits of the operand widened to EW (sign-extended if `a_signed`, else zero-extended) moved left by `b`; vacated low bits are 0.
- R2: Mode 1 (logical right): the operand widened to EW (sign-extended if `a_signed`) is moved right by `b`; any position at or above EW reads 0.
- R3: Mode 2 (arithmetic left): the operand is not widened; positions at or above AW read `a[AW-1]` when `a_signed` is 1 and 0 otherwise; vacated low bits are 0.
- R4: Mode 3 (arithmetic right): positions at or above AW read `a[AW-1]` when `a_signed` is 1 and 0 otherwise, so an unsigned operand behaves as a logical right shift.
- R5: Mode 4 (bidirectional): the operand is widened to EW as in R2; `b` is two's complement when `b_signed` is 1, a non-negative amount moves right and a negative amount moves left by its magnitude; every out-of-range position reads 0.
- R6: Mode 5 (bidirectional, undefined fill): direction rule as in R5, the operand is not widened, and every position outside bits 0..AW-1 on either side reads `fill_bit`.
- R7: In modes 0 to 3, `b` is unsigned whatever `b_signed` says.
- R8: When EW exceeds YW, the result is the low YW bits of the shifted value.
- R9: An amount that moves every output position out of range gives all fill bits (0, `fill_bit`, or the sign bit in arithmetic right with `a_signed`); the amount never wraps around.
- R10: Operation codes 6 and 7 produce `y` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | AW | Data operand |
| b | input | BW | Shift amount |
| a_signed | input | 1 | 1: operand is two's complement |
| b_signed | input | 1 | 1: amount is two's complement (bidirectional modes only) |
| mode | input | 3 | Operation code: 0 lsl, 1 lsr, 2 asl, 3 asr, 4 bidirectional, 5 bidirectional undefined fill |
| fill_bit | input | 1 | Fill value for out-of-range positions in mode 5 |
| y | output | YW | Result |

## Verification
The bench sweeps every combination of operand, amount, both flags, fill bit and operation code on two small configurations. One has an output wider than the operand, so widening is visible. The other has an output narrower than the operand, so truncation is visible. A design that widened in the arithmetic or undefined-fill modes would show the wrong bits above AW. One that capped logical-right at AW instead of EW, or let arithmetic right stop at EW, would diverge on large amounts for negative operands. Honouring `b_signed` in the one-way modes would turn an amount of 6 or 7 into a reverse move. Directed cases also cover negative bidirectional amounts, wraparound of amounts beyond the width, and the reserved codes.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASL = 3'd2,
    SH_ASR = 3'd3,
    SH_BI  = 3'd4,
    SH_BIX = 3'd5
  } shift_op_e;

  function automatic int max_int(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/bshift_extend.sv
module bshift_extend #(
  parameter int AW = 8,
  parameter int EW = 8
) (
  input  logic [AW-1:0] a,
  input  logic          a_signed,
  output logic [EW-1:0] ext
);
  generate
    if (EW > AW) begin : g_widen
      logic top;
      assign top = a_signed & a[AW-1];
      assign ext = {{(EW-AW){top}}, a};
    end else begin : g_same
      assign ext = a;
    end
  endgenerate
endmodule

// File: rtl/bshift_offset.sv
module bshift_offset #(
  parameter int BW = 4
) (
  input  logic [BW-1:0]      amt,
  input  logic               amt_signed,
  input  logic               go_left,
  output logic signed [BW:0] offset
);
  logic signed [BW:0] mag;
  assign mag    = {amt_signed & amt[BW-1], amt};
  assign offset = go_left ? -mag : mag;
endmodule

// File: rtl/bshift_pick.sv
module bshift_pick #(
  parameter int EW  = 8,
  parameter int PW  = 8,
  parameter int IXW = 3
) (
  input  logic [EW-1:0]        data,
  input  logic signed [PW-1:0] pos,
  input  logic signed [PW-1:0] limit,
  input  logic                 lo_fill,
  input  logic                 hi_fill,
  output logic                 bit_out
);
  always_comb begin
    if (pos[PW-1])          bit_out = lo_fill;
    else if (pos >= limit)  bit_out = hi_fill;
    else                    bit_out = data[pos[IXW-1:0]];
  end
endmodule

// File: rtl/bshift.sv
module bshift
  import bshift_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 4,
  parameter int YW = 8
) (
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic          a_signed,
  input  logic          b_signed,
  input  logic [2:0]    mode,
  input  logic          fill_bit,
  output logic [YW-1:0] y
);
  localparam int EW  = max_int(YW, AW);
  localparam int IXW = (EW > 1) ? $clog2(EW) : 1;
  localparam int PW  = max_int(BW + 1, IXW + 2) + 1;
  localparam logic signed [PW-1:0] LIM_RAW = PW'(AW);
  localparam logic signed [PW-1:0] LIM_EXT = PW'(EW);

  logic go_left, bidir, raw_op, mode_ok, msb_fill;
  logic lo_fill, hi_fill;
  logic [EW-1:0] ext, data;
  logic signed [BW:0] offset;
  logic signed [PW-1:0] limit;
  logic [YW-1:0] y_raw;

  assign go_left  = (mode == SH_LSL) || (mode == SH_ASL);
  assign bidir    = (mode == SH_BI)  || (mode == SH_BIX);
  assign raw_op   = (mode == SH_ASL) || (mode == SH_ASR) || (mode == SH_BIX);
  assign mode_ok  = (mode <= SH_BIX);
  assign msb_fill = a_signed & a[AW-1];

  always_comb begin
    lo_fill = 1'b0;
    hi_fill = 1'b0;
    if (mode == SH_BIX) begin
      lo_fill = fill_bit;
      hi_fill = fill_bit;
    end else if ((mode == SH_ASL) || (mode == SH_ASR)) begin
      hi_fill = msb_fill;
    end
  end

  bshift_extend #(.AW(AW), .EW(EW)) u_ext (
    .a(a), .a_signed(a_signed), .ext(ext)
  );

  bshift_offset #(.BW(BW)) u_off (
    .amt(b), .amt_signed(b_signed & bidir), .go_left(go_left), .offset(offset)
  );

  assign data  = raw_op ? EW'(a) : ext;
  assign limit = raw_op ? LIM_RAW : LIM_EXT;

  generate
    for (genvar i = 0; i < YW; i++) begin : g_lane
      logic signed [PW-1:0] pos;
      assign pos = $signed(PW'(i)) + PW'(offset);
      bshift_pick #(.EW(EW), .PW(PW), .IXW(IXW)) u_pick (
        .data(data), .pos(pos), .limit(limit),
        .lo_fill(lo_fill), .hi_fill(hi_fill), .bit_out(y_raw[i])
      );
    end
  endgenerate

  assign y = mode_ok ? y_raw : '0;
endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
  parameter int AW = 8,
  parameter int BW = 4,
  parameter int YW = 8
) (
  input logic [AW-1:0] a,
  input logic [BW-1:0] b,
  input logic          a_signed,
  input logic          b_signed,
  input logic [2:0]    mode,
  input logic          fill_bit,
  input logic [YW-1:0] y
);
  logic [YW-1:0] low_mask;
  always_comb low_mask = (YW'(1) << b) - YW'(1);

  always_comb begin
    if (mode > 3'd5)
      p_reserved_zero_r10: assert (y == '0);
    if (mode == 3'd0 && int'(b) >= YW)
      p_lsl_no_wrap_r9: assert (y == '0);
    if (mode == 3'd0 && int'(b) < YW)
      p_lsl_low_zero_r1: assert ((y & low_mask) == '0);
    if (mode == 3'd3 && a_signed && int'(b) >= AW)
      p_asr_sign_run_r4: assert (y == {YW{a[AW-1]}});
    if (mode == 3'd5 && !b_signed && int'(b) >= AW)
      p_bix_all_fill_r6: assert (y == {YW{fill_bit}});
  end
endmodule

bind bshift bshift_chk #(.AW(AW), .BW(BW), .YW(YW)) u_chk (
  .a(a), .b(b), .a_signed(a_signed), .b_signed(b_signed),
  .mode(mode), .fill_bit(fill_bit), .y(y)
);

// File: tb/bshift_test.sv
module bshift_test;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [3:0] a1 = '0;
  logic [4:0] a2 = '0;
  logic [2:0] b = '0;
  logic a_signed = 1'b0, b_signed = 1'b0, fill_bit = 1'b0;
  logic [2:0] mode = '0;
  logic [5:0] y1;
  logic [2:0] y2;

  int checks = 0;
  int errors = 0;

  bshift #(.AW(4), .BW(BW), .YW(6)) uut (
    .a(a1), .b(b), .a_signed(a_signed), .b_signed(b_signed),
    .mode(mode), .fill_bit(fill_bit), .y(y1)
  );

  bshift #(.AW(5), .BW(BW), .YW(3)) uut_narrow (
    .a(a2), .b(b), .a_signed(a_signed), .b_signed(b_signed),
    .mode(mode), .fill_bit(fill_bit), .y(y2)
  );

  function automatic longint model(input int aw, input int yw, input int m,
                                   input longint av, input longint bv,
                                   input bit as, input bit bs, input bit fl);
    int ew = (yw > aw) ? yw : aw;
    longint mask_y = (longint'(1) << yw) - 1;
    longint mask_e = (longint'(1) << ew) - 1;
    longint mask_a = (longint'(1) << aw) - 1;
    longint sva, ext, s, r, dat, vld;
    sva = (as && av[aw-1]) ? av - (longint'(1) << aw) : av;
    ext = sva & mask_e;
    s = (bs && bv[BW-1]) ? bv - (longint'(1) << BW) : bv;
    case (m)
      0: r = sva << bv;
      1: r = ext >> bv;
      2: r = sva << bv;
      3: r = sva >>> bv;
      4: r = (s >= 0) ? (ext >> s) : (ext << (-s));
      5: begin
        dat = (s >= 0) ? (av >> s) : (av << (-s));
        vld = (s >= 0) ? (mask_a >> s) : (mask_a << (-s));
        r = (dat & vld) | (fl ? ~vld : longint'(0));
      end
      default: r = 0;
    endcase
    return r & mask_y;
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s mode=%0d a1=%0h a2=%0h b=%0h as=%0b bs=%0b fill=%0b actual=%0h expected=%0h",
               tag, mode, a1, a2, b, a_signed, b_signed, fill_bit, act, exp);
    end
  endtask

  task automatic drive(input int m, input int av, input int bv,
                       input bit as, input bit bs, input bit fl);
    mode = 3'(m); a1 = 4'(av); a2 = 5'(av); b = 3'(bv);
    a_signed = as; b_signed = bs; fill_bit = fl;
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: all-zero inputs give zero result
    check("R1 idle", y1, 0);
    check("R1 idle", y2, 0);

    for (int m = 0; m < 8; m++)
      for (int av = 0; av < 32; av++)
        for (int bv = 0; bv < 8; bv++)
          for (int f = 0; f < 4; f++)
            for (int fl = 0; fl < 2; fl++) begin
              drive(m, av, bv, f[0], f[1], fl[0]);
              if (av < 16)
                check(tag_of(m), y1, model(4, 6, m, av & 15, bv, f[0], f[1], fl[0]));
              check(tag_of(m), y2, model(5, 3, m, av, bv, f[0], f[1], fl[0]));
            end

    // R7: b_signed ignored in one-way modes; amount 6 stays a right move of 6
    drive(1, 4'b1000, 3'b110, 1'b1, 1'b1, 1'b0);
    check("R7 lsr", y1, 6'b000000);
    drive(0, 4'b0001, 3'b101, 1'b0, 1'b1, 1'b0);
    check("R7 lsl", y1, 6'b100000);
    // R8: 10110 << 1 = 101100, low 3 bits 100
    drive(0, 5'b10110, 1, 1'b0, 1'b0, 1'b0);
    check("R8 trunc", y2, 3'b100);
    // R9: signed 1000 widened to 111000, >>7 gives 0 in lsr, all ones in asr
    drive(1, 4'b1000, 7, 1'b1, 1'b0, 1'b0);
    check("R9 lsr", y1, 6'b000000);
    drive(3, 4'b1000, 7, 1'b1, 1'b0, 1'b0);
    check("R9 asr", y1, 6'b111111);
    // R5: amount -1 moves 0101 left by one
    drive(4, 4'b0101, 3'b111, 1'b0, 1'b1, 1'b0);
    check("R5 neg", y1, 6'b001010);
    // R6: 0011 right by one with fill 1
    drive(5, 4'b0011, 1, 1'b0, 1'b0, 1'b1);
    check("R6 fill", y1, 6'b111001);
    // R10: reserved code
    drive(7, 4'b1111, 0, 1'b1, 1'b0, 1'b1);
    check("R10 reserved", y1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule